// File: doc/BRIEF.md
# Power-Mode and Wake-Up Controller

This block holds the low-power mode that software selects and turns it into two gating outputs: one for the CPU clock and one for the oscillator. There are four modes: run, idle, power-down and total power-down. Idle stops only the CPU clock. Both power-down modes also stop the oscillator. While the CPU is stopped, the block watches the interrupt and reset requests and decides when the device should come back to run.

An interrupt source can wake the device only when three things hold: its request is raised, its own enable is set, and the global interrupt enable is set. Which sources are allowed to wake the device depends on the mode:

- Idle: any source.
- Power-down: only the sources in a fixed mask. These are the sources that keep working without the oscillator.
- Total power-down: a smaller fixed mask.

A reset source is counted only when its reset enable is set. An enabled reset request produces a system reset request in any mode, and also wakes the device from a low-power mode.

When the device leaves either power-down mode, the oscillator restarts at once. The CPU clock stays gated while a settle counter of programmable length runs down, which models the oscillator start-up time. The block has no data stream, so every pin is a plain level or pulse signal with no handshake.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (run), `cpu_clk_en` and `osc_en` are 1, and `wake_pulse` and `sys_rst_req` are 0.
- R2: A write with `mode_we` high is accepted only while the CPU is running (mode 0 and no settle in progress). The new mode appears on `mode` one cycle later, encoded as 0 run, 1 idle, 2 power-down, 3 total power-down. A write at any other time leaves `mode` unchanged.
- R3: In idle (mode 1), `cpu_clk_en` is 0 and `osc_en` is 1.
- R4: In power-down or total power-down (mode 2 or 3), both `cpu_clk_en` and `osc_en` are 0.
- R5: In idle, any source i with `irq_req[i]`, `irq_en[i]` and `glob_en` all high returns `mode` to 0 one cycle later. `cpu_clk_en` rises in that same cycle.
- R6: In power-down, only the sources set in `PD_MASK` can wake the device. In total power-down, only the sources set in `TPD_MASK` can wake it. The defaults are all sources except the top one for power-down, and sources 0 and 1 for total power-down. A request from any other source leaves `mode` unchanged.
- R7: While `glob_en` is 0, no interrupt request changes a low-power mode.
- R8: When any reset source j has both `rst_req[j]` and `rst_en[j]` high, `sys_rst_req` is 1 one cycle later and `mode` becomes 0, in any mode. A reset request whose enable is clear has no effect.
- R9: `wake_pulse` is 1 for exactly the one cycle after a wake from mode 1, 2 or 3 (by interrupt or by reset), and is 0 otherwise.
- R10: After a wake from mode 2 or 3, `osc_en` is 1 at once. `cpu_clk_en` stays 0 for `settle_len` cycles, using the value sampled in the wake cycle, and is 1 after that. A `settle_len` of 0 gives an immediate start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode value to write |
| settle_len | input | SETTLE_W | Number of oscillator settle cycles after a wake from power-down |
| irq_req | input | NSRC | Interrupt request, one bit per source |
| irq_en | input | NSRC | Interrupt enable, one bit per source |
| glob_en | input | 1 | Global interrupt enable |
| rst_req | input | NRST | Reset request, one bit per reset source |
| rst_en | input | NRST | Reset enable, one bit per reset source |
| mode | output | 2 | Current power mode |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | One-cycle pulse on leaving a low-power mode |
| sys_rst_req | output | 1 | System reset request |

## Verification
Every result is registered once:

- A mode write, a wake or a reset request sampled at a rising edge shows on `mode`, `wake_pulse` and `sys_rst_req` right after that same edge.
- The gating outputs follow from the registered state with no further delay.
- After a wake from power-down, `cpu_clk_en` rises `settle_len` edges later than the wake.

The bench drives its inputs just after a falling edge and compares at the next falling edge, so each check sees exactly one rising edge of effect. The settle window is checked edge by edge against a count kept in the bench.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_PD   = 2'd2,
    PM_TPD  = 2'd3
  } pmode_t;

  function automatic logic osc_off(pmode_t m);
    return (m == PM_PD) || (m == PM_TPD);
  endfunction
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
  import pwr_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int NRST = 4,
  parameter logic [NSRC-1:0] PD_MASK  = {1'b0, {(NSRC-1){1'b1}}},
  parameter logic [NSRC-1:0] TPD_MASK = {{(NSRC-2){1'b0}}, 2'b11}
) (
  input  pmode_t          cur_mode,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            glob_en,
  input  logic [NRST-1:0] rst_req,
  input  logic [NRST-1:0] rst_en,
  output logic            irq_wake,
  output logic            rst_hit
);
  logic [NSRC-1:0] allow;
  logic [NSRC-1:0] live;

  // The set of sources that may wake the device depends on the mode.
  always_comb begin
    unique case (cur_mode)
      PM_IDLE: allow = '1;
      PM_PD:   allow = PD_MASK;
      PM_TPD:  allow = TPD_MASK;
      default: allow = '0;
    endcase
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign live[i] = irq_req[i] & irq_en[i] & allow[i];
  end

  assign irq_wake = glob_en & (|live);
  assign rst_hit  = |(rst_req & rst_en);
endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         busy
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_pkg::*;
#(
  parameter int NSRC     = 8,
  parameter int NRST     = 4,
  parameter int SETTLE_W = 16,
  parameter logic [NSRC-1:0] PD_MASK  = {1'b0, {(NSRC-1){1'b1}}},
  parameter logic [NSRC-1:0] TPD_MASK = {{(NSRC-2){1'b0}}, 2'b11}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_we,
  input  logic [1:0]          mode_wdata,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic [NSRC-1:0]     irq_req,
  input  logic [NSRC-1:0]     irq_en,
  input  logic                glob_en,
  input  logic [NRST-1:0]     rst_req,
  input  logic [NRST-1:0]     rst_en,
  output logic [1:0]          mode,
  output logic                cpu_clk_en,
  output logic                osc_en,
  output logic                wake_pulse,
  output logic                sys_rst_req
);
  pmode_t mode_q;
  logic   wake_q, rreq_q;
  logic   irq_wake, rst_hit, busy, cpu_run, leave, settle_load;

  pwr_wake_detect #(
    .NSRC(NSRC), .NRST(NRST), .PD_MASK(PD_MASK), .TPD_MASK(TPD_MASK)
  ) u_det (
    .cur_mode(mode_q), .irq_req(irq_req), .irq_en(irq_en), .glob_en(glob_en),
    .rst_req(rst_req), .rst_en(rst_en), .irq_wake(irq_wake), .rst_hit(rst_hit)
  );

  assign cpu_run     = (mode_q == PM_RUN) && !busy;
  assign leave       = (mode_q != PM_RUN) && (irq_wake || rst_hit);
  assign settle_load = leave && osc_off(mode_q);

  pwr_settle_cnt #(.W(SETTLE_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .len(settle_len), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_RUN;
      wake_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      rreq_q <= rst_hit;
      wake_q <= leave;
      if (rst_hit || leave) begin
        mode_q <= PM_RUN;
      end else if (mode_we && cpu_run) begin
        mode_q <= pmode_t'(mode_wdata);
      end
    end
  end

  assign mode        = mode_q;
  assign osc_en      = !osc_off(mode_q);
  assign cpu_clk_en  = cpu_run;
  assign wake_pulse  = wake_q;
  assign sys_rst_req = rreq_q;
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk #(
  parameter int NRST     = 4,
  parameter int SETTLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode,
  input logic                cpu_clk_en,
  input logic                osc_en,
  input logic                wake_pulse,
  input logic                sys_rst_req,
  input logic                glob_en,
  input logic [NRST-1:0]     rst_req,
  input logic [NRST-1:0]     rst_en,
  input logic [SETTLE_W-1:0] settle_len
);
  // R3
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (!cpu_clk_en && osc_en));

  // R4
  pd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (!cpu_clk_en && !osc_en));

  // R7
  noglob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != 2'd0) && !glob_en && ((rst_req & rst_en) == '0)) |=> (mode == $past(mode)));

  // R8
  rst_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (mode == 2'd0));

  // R9
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> ((mode == 2'd0) && ($past(mode) != 2'd0)));

  // R10
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode[1]) && (mode == 2'd0) && ($past(settle_len) != '0)) |-> !cpu_clk_en);
endmodule

bind pwr_wake_ctrl pwr_wake_chk #(.NRST(NRST), .SETTLE_W(SETTLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
  .wake_pulse(wake_pulse), .sys_rst_req(sys_rst_req), .glob_en(glob_en),
  .rst_req(rst_req), .rst_en(rst_en), .settle_len(settle_len)
);

// File: tb/sim_pwr_wake_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_wake_ctrl;
  localparam int NSRC = 8;
  localparam int NRST = 4;
  localparam int SW   = 6;
  localparam logic [NSRC-1:0] PDM  = 8'h7F;
  localparam logic [NSRC-1:0] TPDM = 8'h03;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 1'b0;
  logic [1:0] mode_wdata = '0;
  logic [SW-1:0] settle_len = '0;
  logic [NSRC-1:0] irq_req = '0, irq_en = '0;
  logic glob_en = 1'b0;
  logic [NRST-1:0] rst_req = '0, rst_en = '0;
  logic [1:0] mode;
  logic cpu_clk_en, osc_en, wake_pulse, sys_rst_req;

  int total = 0, bad = 0;
  bit chk_on = 1'b0;
  int em = 0, ecnt = 0, ew = 0, er = 0;
  logic [NSRC-1:0] m_allow;
  bit m_rh, m_iw, m_lv, m_run;

  always #10 clk = ~clk;

  pwr_wake_ctrl #(.NSRC(NSRC), .NRST(NRST), .SETTLE_W(SW), .PD_MASK(PDM), .TPD_MASK(TPDM)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .settle_len(settle_len), .irq_req(irq_req), .irq_en(irq_en), .glob_en(glob_en),
    .rst_req(rst_req), .rst_en(rst_en), .mode(mode), .cpu_clk_en(cpu_clk_en),
    .osc_en(osc_en), .wake_pulse(wake_pulse), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      em = 0; ecnt = 0; ew = 0; er = 0;
    end else begin
      m_allow = (em == 1) ? '1 : (em == 2) ? PDM : (em == 3) ? TPDM : '0;
      m_rh  = |(rst_req & rst_en);
      m_iw  = glob_en && |(irq_req & irq_en & m_allow);
      m_lv  = (em != 0) && (m_iw || m_rh);
      m_run = (em == 0) && (ecnt == 0);
      ew = m_lv; er = m_rh;
      if (m_lv && em >= 2) ecnt = settle_len;
      else if (ecnt > 0) ecnt--;
      if (m_rh || m_lv) em = 0;
      else if (mode_we && m_run) em = mode_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      chk("R2 R5 R6 R7 R8 mode", mode, em);
      chk("R3 R4 R10 cpu_clk_en", cpu_clk_en, (em == 0 && ecnt == 0));
      chk("R3 R4 R10 osc_en", osc_en, (em < 2));
      chk("R9 wake_pulse", wake_pulse, ew);
      chk("R8 sys_rst_req", sys_rst_req, er);
    end
  end

  task automatic quiet();
    mode_we = 0; irq_req = '0; rst_req = '0;
  endtask

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic wr(int v);
    quiet(); mode_we = 1; mode_wdata = v[1:0]; step(); mode_we = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 wake_pulse", wake_pulse, 0);
    chk("R1 sys_rst_req", sys_rst_req, 0);
    chk_on = 1'b1;
    #2;
    // R2 R3: enter idle
    wr(1);
    chk("R2 idle write", mode, 1);
    chk("R3 cpu gated", cpu_clk_en, 0);
    chk("R3 osc kept", osc_en, 1);
    // R5: any enabled source wakes idle
    irq_req = 8'h20; irq_en = 8'h20; glob_en = 1; step(); quiet();
    chk("R5 idle wake", mode, 0);
    chk("R5 cpu resumes", cpu_clk_en, 1);
    chk("R9 pulse", wake_pulse, 1);
    step();
    chk("R9 pulse single", wake_pulse, 0);
    // R4: power-down
    settle_len = 3; wr(2);
    chk("R4 pd osc", osc_en, 0);
    chk("R4 pd cpu", cpu_clk_en, 0);
    wr(1);
    chk("R2 write ignored in pd", mode, 2);
    // R6: top source not in power-down mask
    irq_req = 8'h80; irq_en = 8'hFF; glob_en = 1; step(); quiet();
    chk("R6 masked source", mode, 2);
    // R7: no global enable
    glob_en = 0; irq_req = 8'h01; step(); quiet();
    chk("R7 glob off", mode, 2);
    // R10: wake with settle
    glob_en = 1; irq_req = 8'h01; step(); quiet();
    chk("R10 wake mode", mode, 0);
    chk("R10 osc on", osc_en, 1);
    chk("R10 cpu held", cpu_clk_en, 0);
    mode_we = 1; mode_wdata = 2'd1; step(); mode_we = 0;
    chk("R2 write ignored in settle", mode, 0);
    chk("R10 cpu held 2", cpu_clk_en, 0);
    step();
    chk("R10 cpu held 3", cpu_clk_en, 0);
    step();
    chk("R10 cpu start", cpu_clk_en, 1);
    // R6: total power-down, zero settle
    settle_len = 0; wr(3);
    irq_req = 8'h04; step(); quiet();
    chk("R6 tpd mask", mode, 3);
    irq_req = 8'h02; step(); quiet();
    chk("R10 zero settle", cpu_clk_en, 1);
    // R8: reset requests
    wr(1);
    rst_req = 4'b0100; rst_en = 4'b1011; step(); quiet();
    chk("R8 disabled reset", mode, 1);
    chk("R8 no req", sys_rst_req, 0);
    rst_req = 4'b0100; rst_en = 4'b0100; step(); quiet();
    chk("R8 reset req", sys_rst_req, 1);
    chk("R8 reset wakes", mode, 0);
    chk("R9 reset pulse", wake_pulse, 1);
    rst_req = 4'b0001; rst_en = 4'b0001; step(); quiet();
    chk("R9 no pulse in run", wake_pulse, 0);
    chk("R8 run reset", sys_rst_req, 1);
    // Constrained random phase
    for (int c = 0; c < 4000; c++) begin
      mode_we    = ($urandom % 4) == 0;
      mode_wdata = $urandom % 4;
      settle_len = $urandom % 8;
      irq_en     = $urandom;
      glob_en    = ($urandom % 4) != 0;
      rst_en     = $urandom;
      for (int i = 0; i < NSRC; i++) irq_req[i] = ($urandom % 24) == 0;
      for (int j = 0; j < NRST; j++) rst_req[j] = ($urandom % 80) == 0;
      step();
    end
    quiet();
    step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule